// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the logic core of a small programmable logic device. Sixteen signals enter it: eight dedicated inputs and eight signals fed back from the output cells or taken from the pins. Each signal is expanded into a true line and a complement line, which gives thirty-two array lines. Sixty-four product terms each AND together the lines that a stored connection map selects. The terms are then ORed in eight groups of eight to produce eight sum outputs.

The eighth term of each group is an auxiliary term. A per-group select input decides how it is used. When the select is high, the term joins its group's OR. When the select is low, the term is left out of the OR and is driven on a separate output, where the surrounding cell can use it as an output-enable condition.

The connection map is a plain register array with one row per product term. A single-row write port loads it. From the inputs and the stored map to the outputs, the path is purely combinational.

Top module: `pterm_array`

## Requirements
- R1: After reset every connection is open. With every select low, all eight sum outputs and all eight auxiliary outputs read 1.
- R2: Array line 2k carries signal k and line 2k+1 carries its inverse. Signals 0 to 7 are `ded_in[0..7]` and signals 8 to 15 are `fb_in[0..7]`.
- R3: Product term g*8+j belongs to group g. Indices j = 0 to 6 are the group's fixed OR terms and j = 7 is its auxiliary term. A write of `cfg_data` to `cfg_addr` sets that term's row, where bit l = 1 connects array line l.
- R4: A product term whose row is all zeros evaluates to 1.
- R5: A product term that connects both lines of the same signal evaluates to 0 for every input value.
- R6: Any other product term is the AND of exactly the lines it connects. Unconnected lines have no influence on it.
- R7: When `aux_join[g]` is 1, the auxiliary term of group g is ORed into `sum_out[g]` and `pt_oe[g]` is 0.
- R8: When `aux_join[g]` is 0, `pt_oe[g]` equals the auxiliary term of group g and `sum_out[g]` is the OR of the seven fixed terms only.
- R9: A write changes the stored row at the next rising clock edge and not before. While `cfg_we` is 0, the map does not change, whatever appears on `cfg_addr` and `cfg_data`.
- R10: The sum and auxiliary outputs follow changes on `ded_in`, `fb_in` and `aux_join` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Asynchronous active-low reset; opens every connection |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | 6 | Index of the product term being written |
| cfg_data | input | 32 | Connection row; bit l selects array line l |
| ded_in | input | 8 | Dedicated input signals |
| fb_in | input | 8 | Feedback or pin signals |
| aux_join | input | 8 | Per-group select: 1 joins the auxiliary term into the OR |
| sum_out | output | 8 | Sum-of-products result for each group |
| pt_oe | output | 8 | Auxiliary term per group when not joined, else 0 |

## Verification
The routing of the auxiliary term is hard to observe. Right after reset every term reads 1, so every sum is 1 no matter where the auxiliary term goes. The stimulus therefore first programs all sixty-four rows with a clashing pair of connections, which forces every term to 0. It then opens one auxiliary term at a time so that it alone decides `sum_out` and `pt_oe` as `aux_join` toggles. Random sparse rows, written while the inputs change, then cover partial connections and write timing. A behavioural model checks both outputs on every clock.

// File: rtl/pta_pkg.sv
package pta_pkg;
    localparam int DEF_N_DED         = 8;
    localparam int DEF_N_FB          = 8;
    localparam int DEF_N_GRP         = 8;
    localparam int DEF_TERMS_PER_GRP = 8;
endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store #(
    parameter int N_TERM = 64,
    parameter int N_LINE = 32,
    parameter int AW     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [N_LINE-1:0]        wr_row,
    output logic [N_TERM*N_LINE-1:0] map_flat
);
    logic [N_LINE-1:0] rows [N_TERM];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERM; t++) begin
                rows[t] <= '0;
            end
        end else if (wr_en) begin
            rows[wr_addr] <= wr_row;
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_flat
        assign map_flat[t*N_LINE +: N_LINE] = rows[t];
    end

    // R9
    wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> map_flat[int'($past(wr_addr))*N_LINE +: N_LINE] == $past(wr_row));

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(map_flat));
endmodule

// File: rtl/pta_line_gen.sv
module pta_line_gen #(
    parameter int N_DED = 8,
    parameter int N_FB  = 8,
    localparam int N_SIG  = N_DED + N_FB,
    localparam int N_LINE = 2 * N_SIG
) (
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_FB-1:0]   fb_in,
    output logic [N_LINE-1:0] lines
);
    logic [N_SIG-1:0] sig;
    assign sig = {fb_in, ded_in};

    for (genvar k = 0; k < N_SIG; k++) begin : g_pair
        assign lines[2*k]   = sig[k];
        assign lines[2*k+1] = ~sig[k];
    end
endmodule

// File: rtl/pta_term.sv
module pta_term #(
    parameter int N_LINE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LINE-1:0] row,
    input  logic [N_LINE-1:0] lines,
    output logic              term_hi
);
    always_comb begin
        term_hi = &(~row | lines);
    end

    logic clash;
    always_comb begin
        clash = 1'b0;
        for (int k = 0; k < N_LINE/2; k++) begin
            clash = clash | (row[2*k] & row[2*k+1]);
        end
    end

    // R4
    empty_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row == '0) |-> term_hi);

    // R5
    clash_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> !term_hi);
endmodule

// File: rtl/pta_or_group.sv
module pta_or_group #(
    parameter int TPG = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TPG-1:0] terms,
    input  logic           join_aux,
    output logic           sum_hi,
    output logic           oe_term
);
    logic [TPG-2:0] fixed_terms;
    logic           aux_term;

    always_comb begin
        fixed_terms = terms[TPG-2:0];
        aux_term    = terms[TPG-1];
        sum_hi      = (|fixed_terms) | (join_aux & aux_term);
        oe_term     = ~join_aux & aux_term;
    end

    // R7
    joined_oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        join_aux |-> !oe_term);

    // R7
    joined_aux_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (join_aux && terms[TPG-1]) |-> sum_hi);

    // R8
    split_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!join_aux && terms[TPG-2:0] == '0) |-> !sum_hi);
endmodule

// File: rtl/pterm_array.sv
module pterm_array #(
    parameter int N_DED         = pta_pkg::DEF_N_DED,
    parameter int N_FB          = pta_pkg::DEF_N_FB,
    parameter int N_GRP         = pta_pkg::DEF_N_GRP,
    parameter int TERMS_PER_GRP = pta_pkg::DEF_TERMS_PER_GRP,
    localparam int N_SIG  = N_DED + N_FB,
    localparam int N_LINE = 2 * N_SIG,
    localparam int N_TERM = N_GRP * TERMS_PER_GRP,
    localparam int AW     = $clog2(N_TERM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [N_LINE-1:0] cfg_data,
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_FB-1:0]   fb_in,
    input  logic [N_GRP-1:0]  aux_join,
    output logic [N_GRP-1:0]  sum_out,
    output logic [N_GRP-1:0]  pt_oe
);
    logic [N_TERM*N_LINE-1:0] map_flat;
    logic [N_LINE-1:0]        lines;
    logic [N_TERM-1:0]        terms;

    pta_cfg_store #(.N_TERM(N_TERM), .N_LINE(N_LINE), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_row   (cfg_data),
        .map_flat (map_flat)
    );

    pta_line_gen #(.N_DED(N_DED), .N_FB(N_FB)) u_lines (
        .ded_in (ded_in),
        .fb_in  (fb_in),
        .lines  (lines)
    );

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        pta_term #(.N_LINE(N_LINE)) u_term (
            .clk     (clk),
            .rst_n   (rst_n),
            .row     (map_flat[t*N_LINE +: N_LINE]),
            .lines   (lines),
            .term_hi (terms[t])
        );
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        pta_or_group #(.TPG(TERMS_PER_GRP)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .terms    (terms[g*TERMS_PER_GRP +: TERMS_PER_GRP]),
            .join_aux (aux_join[g]),
            .sum_hi   (sum_out[g]),
            .oe_term  (pt_oe[g])
        );
    end
endmodule

// File: tb/pterm_array_tb.sv
module pterm_array_tb;
    localparam int NT = 64;
    localparam int NL = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [31:0] cfg_data;
    logic [7:0]  ded_in;
    logic [7:0]  fb_in;
    logic [7:0]  aux_join;
    logic [7:0]  sum_out;
    logic [7:0]  pt_oe;

    always #10 clk = ~clk;

    pterm_array u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .ded_in   (ded_in),
        .fb_in    (fb_in),
        .aux_join (aux_join),
        .sum_out  (sum_out),
        .pt_oe    (pt_oe)
    );

    bit [31:0] model [NT];
    int        checks = 0;
    int        fails  = 0;
    bit        done   = 1'b0;
    string     cur_req = "R1";

    function automatic bit line_val(int l);
        int  s = l / 2;
        bit  v = (s < 8) ? ded_in[s] : fb_in[s-8];
        return (l % 2 == 1) ? !v : v;
    endfunction

    function automatic bit term_val(int t);
        bit r = 1'b1;
        for (int l = 0; l < NL; l++) begin
            if (model[t][l] && !line_val(l)) r = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_sum();
        logic [7:0] s = '0;
        for (int g = 0; g < 8; g++) begin
            for (int j = 0; j < 7; j++) s[g] = s[g] | term_val(g*8+j);
            if (aux_join[g]) s[g] = s[g] | term_val(g*8+7);
        end
        return s;
    endfunction

    function automatic logic [7:0] exp_oe();
        logic [7:0] s = '0;
        for (int g = 0; g < 8; g++) s[g] = !aux_join[g] && term_val(g*8+7);
        return s;
    endfunction

    task automatic check8(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic step(bit we, int addr, bit [31:0] data,
                        bit [7:0] d, bit [7:0] f, bit [7:0] j);
        @(negedge clk);
        cfg_we   = we;
        cfg_addr = addr[5:0];
        cfg_data = data;
        ded_in   = d;
        fb_in    = f;
        aux_join = j;
        #5;
        check8("sum_out", sum_out, exp_sum());
        check8("pt_oe", pt_oe, exp_oe());
        @(posedge clk);
        if (we) model[addr] = data;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
        ded_in = '0; fb_in = '0; aux_join = '0;
        for (int t = 0; t < NT; t++) model[t] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: erased map, all selects low -> every output 1
        cur_req = "R1";
        step(0, 0, 0, 8'h5A, 8'hC3, 8'h00);
        @(negedge clk); #5;
        check8("reset sum_out", sum_out, 8'hFF);
        check8("reset pt_oe", pt_oe, 8'hFF);

        // R5: clashing pair in every row -> every term 0
        cur_req = "R5";
        for (int t = 0; t < NT; t++)
            step(1, t, 32'h3 << (2 * (t % 16)), 8'(t), 8'(~t), 8'h00);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 8'(i*37), 8'(i*91), 8'(i*29));

        // R4: empty row reads 1 for any input
        cur_req = "R4";
        step(1, 2, 32'h0, 8'h00, 8'h00, 8'h00);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 8'(i*85), 8'(~(i*85)), 8'h00);
        step(1, 2, 32'h3, 8'h00, 8'h00, 8'h00);

        // R2 / R6: term 9 = ded0 & ~fb0, term 18 = ~fb7
        cur_req = "R2/R6";
        step(1, 9, (32'h1 << 0) | (32'h1 << 17), 8'h00, 8'h00, 8'h00);
        step(1, 18, 32'h1 << 31, 8'h00, 8'h00, 8'h00);
        for (int i = 0; i < 16; i++)
            step(0, 0, 0, {7'h55, i[0]}, {i[3], 6'h2A, i[1]}, 8'h00);

        // R7 / R8: auxiliary term of group 2 connected to ded2
        cur_req = "R7/R8";
        step(1, 23, 32'h1 << 4, 8'h00, 8'h00, 8'h00);
        for (int i = 0; i < 8; i++)
            step(0, 0, 0, {5'h0, i[0], 2'b11}, 8'h00, {5'h0, i[1], 2'b0});

        // R10: inputs alone move outputs within the cycle
        cur_req = "R10";
        for (int i = 0; i < 8; i++) step(0, 0, 0, 8'(i*51), 8'(i*13), 8'(i*3));

        // R9: a disabled write leaves the map as it was
        cur_req = "R9";
        step(0, 23, 32'h0, 8'h00, 8'h00, 8'h00);
        step(0, 9, 32'h0, 8'h01, 8'h00, 8'h00);
        step(1, 23, 32'h0, 8'h00, 8'h00, 8'h00);
        step(0, 0, 0, 8'h00, 8'h00, 8'h00);

        // R3: random rows at random term indices
        cur_req = "R3";
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] row = $urandom & $urandom & $urandom;
            if ($urandom % 9 == 0) row = '0;
            step(($urandom % 3) == 0, int'($urandom % 64), row,
                 8'($urandom), 8'($urandom), 8'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule